// File: doc/BRIEF.md
# SCSI Controller Host Register and Command Front End

This block is the host-side register file and command gate of a small SCSI protocol controller. The host reaches it through byte-wide registers placed on 32-bit word boundaries, so the register index comes from address bits 5:2. Several offsets hold a read-only register for reads and a separate write-only register for writes. Those write-only values drive output ports towards the selection sequencer. The block also holds a 16-byte data FIFO, a 24-bit transfer down-counter, the first configuration register, the status and interrupt-cause registers, and the current connection state.

A byte written to the command offset is treated as a command. Bit 7 asks for DMA mode. The low seven bits are checked against the connection state, which a sequencer stub loads. A legal command leaves the block as a one-cycle strobe that carries its code and DMA bit. An illegal command sets an interrupt cause and makes no strobe. Three commands also act inside the block: FIFO flush, chip reset and bus reset.

Top module: `scsi_regfront`

## Requirements
- R1: Register index is host_addr[5:2]. Reads return: 0x00 count bits 7:0, 0x04 count bits 15:8, 0x38 count bits 23:16, 0x08 FIFO head, 0x0C last command byte, 0x20 configuration 1 (read/write, also driven on cfg1_out). Unlisted offsets read 0x00. Read data is combinational from the current state.
- R2: Offsets 0x10, 0x14, 0x18 and 0x1C are split. Writes go to bus ID, selection timeout, sync period and sync offset, which appear on their output ports from the cycle after the write. Reads return status, interrupt cause, {5'b0, seq_step} and FIFO flags, and never the written value.
- R3: Codes 0x00 to 0x03 are legal in every connection state. A legal command write makes cmd_strobe high for the single cycle after the write, with cmd_code equal to the byte's bits 6:0 and cmd_dma equal to its bit 7.
- R4: The connection state is loaded from seq_state_in when seq_state_ld is high: 00 disconnected, 01 connected as initiator, 10 connected in a message phase, 11 reserved. Codes 0x10 to 0x1B are legal only in 01 or 10. Codes 0x20 to 0x2B are legal only in 10. Codes 0x40 to 0x47 are legal only in 00. All other codes are never legal.
- R5: An illegal command sets interrupt bit 6 and makes no strobe. The legality check ignores bit 7.
- R6: Bus reset (0x03) sets interrupt bit 7 unless configuration 1 bit 6 is set.
- R7: The FIFO holds 16 bytes. A write to 0x08 pushes, and is dropped when the FIFO is full. A read of 0x08 pops in first-in order, and returns 0x00 with no pop when the FIFO is empty. The flags register holds the count in bits 4:0 and seq_step in bits 7:5. Flush (0x01) empties the FIFO.
- R8: Status bits: 2:0 bus_phase; 3 sticky transfer done (set by seq_xfer_done); 4 transfer count is zero; 5 sticky parity error (set by par_err); 6 reads 0; 7 interrupt cause is non-zero.
- R9: Interrupt causes are bits of seq_irq, ORed into the interrupt register each cycle. A read of 0x14 returns the register and then clears it, together with status bits 3 and 5. A cause that arrives in the same cycle as the read is kept.
- R10: A write to a count byte loads that byte. Each cycle with xfer_strobe high and no count write decrements the count by one. The count holds at zero.
- R11: Chip reset (0x02) still strobes. In the cycle after the write, every register, the command byte, the count, the FIFO and the interrupt causes are zero, and the state is disconnected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host register write |
| host_rd | input | 1 | Host register read (side effects at the clock edge) |
| host_addr | input | 6 | Byte offset of the register |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data |
| seq_state_ld | input | 1 | Load the connection state |
| seq_state_in | input | 2 | New connection state |
| seq_step | input | 3 | Sequence step from the sequencer |
| seq_irq | input | 8 | Interrupt causes from the sequencer |
| seq_xfer_done | input | 1 | Transfer finished pulse |
| bus_phase | input | 3 | Current bus phase |
| par_err | input | 1 | Parity error pulse |
| xfer_strobe | input | 1 | One byte transferred |
| cmd_strobe | output | 1 | Legal command issued |
| cmd_code | output | 7 | Command code |
| cmd_dma | output | 1 | Command asks for DMA |
| cfg1_out | output | 8 | Configuration 1 |
| bus_id_out | output | 8 | Bus ID |
| sel_timeout_out | output | 8 | Selection timeout |
| sync_period_out | output | 8 | Sync period |
| sync_offset_out | output | 8 | Sync offset |

## Verification
Command codes are swept across all four connection states. Each sweep includes the group edges (0x10, 0x1B, 0x20, 0x2B, 0x40, 0x47) and their outside neighbours, so an off-by-one in any group range shows up as a wrong strobe or a wrong illegal-interrupt bit. Codes are issued with and without bit 7, which shows whether the DMA bit reaches the legality check. The FIFO is filled past capacity and drained past empty, which separates a dropped write from a wrap-around. Bus reset is issued with reset reporting on and off to show that the configuration bit gates only the interrupt and not the strobe.

// File: rtl/scsi_regfront_pkg.sv
package scsi_regfront_pkg;

    localparam int ADDR_W     = 6;
    localparam int IDX_W      = 4;
    localparam int TC_BYTES   = 3;
    localparam int TC_W       = 8 * TC_BYTES;
    localparam int FIFO_DEPTH = 16;

    typedef enum logic [1:0] {
        LINK_FREE = 2'b00,
        LINK_INIT = 2'b01,
        LINK_MSG  = 2'b10,
        LINK_RSVD = 2'b11
    } link_e;

    typedef enum logic [IDX_W-1:0] {
        RI_TC_LO  = 4'd0,
        RI_TC_MID = 4'd1,
        RI_FIFO   = 4'd2,
        RI_CMD    = 4'd3,
        RI_STAT   = 4'd4,
        RI_INTR   = 4'd5,
        RI_STEP   = 4'd6,
        RI_FLAGS  = 4'd7,
        RI_CFG1   = 4'd8,
        RI_TC_HI  = 4'd14
    } reg_idx_e;

    localparam logic [6:0] OP_FLUSH   = 7'h01;
    localparam logic [6:0] OP_CHIPRST = 7'h02;
    localparam logic [6:0] OP_BUSRST  = 7'h03;

    localparam int IRQ_ILLEGAL = 6;
    localparam int IRQ_BUSRST  = 7;
    localparam int CFG1_QUIET  = 6;

    typedef struct packed {
        logic       dma;
        logic [6:0] code;
    } cmd_t;

    function automatic logic cmd_allowed(logic [6:0] c, link_e st);
        if (c <= 7'h03)
            return 1'b1;
        if (c >= 7'h10 && c <= 7'h1B)
            return (st == LINK_INIT) || (st == LINK_MSG);
        if (c >= 7'h20 && c <= 7'h2B)
            return st == LINK_MSG;
        if (c >= 7'h40 && c <= 7'h47)
            return st == LINK_FREE;
        return 1'b0;
    endfunction

endpackage

// File: rtl/scsi_rf_cmd_gate.sv
module scsi_rf_cmd_gate
    import scsi_regfront_pkg::*;
(
    input  logic  cmd_wr,
    input  cmd_t  cmd_in,
    input  link_e link,
    input  logic  rst_report_off,
    output logic  legal,
    output logic  illegal,
    output logic  do_flush,
    output logic  do_chiprst,
    output logic  do_busrst_irq
);
    logic ok;

    always_comb begin
        ok            = cmd_allowed(cmd_in.code, link);
        legal         = cmd_wr && ok;
        illegal       = cmd_wr && !ok;
        do_flush      = legal && (cmd_in.code == OP_FLUSH);
        do_chiprst    = legal && (cmd_in.code == OP_CHIPRST);
        do_busrst_irq = legal && (cmd_in.code == OP_BUSRST) && !rst_report_off;
    end
endmodule

// File: rtl/scsi_rf_fifo.sv
module scsi_rf_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             push,
    input  logic             pop,
    input  logic [W-1:0]     din,
    output logic [W-1:0]     dout,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;

    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);
    assign dout  = mem[rp];

    always_ff @(posedge clk) begin
        if (push && !full)
            mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push && !full)
                wp <= wp + 1'b1;
            if (pop && !empty)
                rp <= rp + 1'b1;
            count <= count + CNT_W'(push && !full) - CNT_W'(pop && !empty);
        end
    end
endmodule

// File: rtl/scsi_rf_xcnt.sv
module scsi_rf_xcnt #(
    parameter int NB = 3,
    localparam int W = 8 * NB
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic [NB-1:0] ld_en,
    input  logic [7:0]    ld_byte,
    input  logic          dec,
    output logic [W-1:0]  count
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (|ld_en) begin
            for (int b = 0; b < NB; b++)
                if (ld_en[b])
                    count[b*8 +: 8] <= ld_byte;
        end else if (dec && count != '0) begin
            count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/scsi_regfront.sv
module scsi_regfront
    import scsi_regfront_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic              seq_state_ld,
    input  logic [1:0]        seq_state_in,
    input  logic [2:0]        seq_step,
    input  logic [7:0]        seq_irq,
    input  logic              seq_xfer_done,
    input  logic [2:0]        bus_phase,
    input  logic              par_err,
    input  logic              xfer_strobe,
    output logic              cmd_strobe,
    output logic [6:0]        cmd_code,
    output logic              cmd_dma,
    output logic [7:0]        cfg1_out,
    output logic [7:0]        bus_id_out,
    output logic [7:0]        sel_timeout_out,
    output logic [7:0]        sync_period_out,
    output logic [7:0]        sync_offset_out
);
    localparam int FCNT_W = $clog2(FIFO_DEPTH) + 1;

    reg_idx_e          idx;
    logic [7:0]        cfg1_q, cmd_q, intr_q;
    logic              xdone_q, perr_q;
    link_e             link_q;
    logic [TC_W-1:0]   tc_q;
    logic [FCNT_W-1:0] fifo_cnt;
    logic [7:0]        fifo_dout;
    logic              fifo_full, fifo_empty;
    logic              wr_cmd, rd_intr;
    logic              legal, illegal, do_flush, do_chiprst, do_busrst_irq;
    cmd_t              cmd_in;
    logic [7:0]        status, fflags, intr_set;

    assign idx     = reg_idx_e'(host_addr[ADDR_W-1:2]);
    assign wr_cmd  = host_wr && idx == RI_CMD;
    assign rd_intr = host_rd && idx == RI_INTR;
    assign cmd_in  = cmd_t'(host_wdata);

    scsi_rf_cmd_gate u_gate (
        .cmd_wr        (wr_cmd),
        .cmd_in        (cmd_in),
        .link          (link_q),
        .rst_report_off(cfg1_q[CFG1_QUIET]),
        .legal         (legal),
        .illegal       (illegal),
        .do_flush      (do_flush),
        .do_chiprst    (do_chiprst),
        .do_busrst_irq (do_busrst_irq)
    );

    scsi_rf_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
        .clk  (clk),
        .rst  (rst),
        .clr  (do_chiprst || do_flush),
        .push (host_wr && idx == RI_FIFO),
        .pop  (host_rd && idx == RI_FIFO),
        .din  (host_wdata),
        .dout (fifo_dout),
        .count(fifo_cnt),
        .full (fifo_full),
        .empty(fifo_empty)
    );

    scsi_rf_xcnt #(.NB(TC_BYTES)) u_xcnt (
        .clk    (clk),
        .rst    (rst),
        .clr    (do_chiprst),
        .ld_en  ({host_wr && idx == RI_TC_HI, host_wr && idx == RI_TC_MID,
                  host_wr && idx == RI_TC_LO}),
        .ld_byte(host_wdata),
        .dec    (xfer_strobe),
        .count  (tc_q)
    );

    always_comb begin
        intr_set = seq_irq;
        intr_set[IRQ_ILLEGAL] = intr_set[IRQ_ILLEGAL] | illegal;
        intr_set[IRQ_BUSRST]  = intr_set[IRQ_BUSRST]  | do_busrst_irq;
    end

    always_ff @(posedge clk) begin
        if (rst || do_chiprst) begin
            cfg1_q          <= '0;
            cmd_q           <= '0;
            intr_q          <= '0;
            xdone_q         <= 1'b0;
            perr_q          <= 1'b0;
            link_q          <= LINK_FREE;
            bus_id_out      <= '0;
            sel_timeout_out <= '0;
            sync_period_out <= '0;
            sync_offset_out <= '0;
        end else begin
            intr_q  <= (rd_intr ? 8'h00 : intr_q) | intr_set;
            xdone_q <= (xdone_q && !rd_intr) || seq_xfer_done;
            perr_q  <= (perr_q && !rd_intr) || par_err;
            if (seq_state_ld)
                link_q <= link_e'(seq_state_in);
            if (host_wr) begin
                unique case (idx)
                    RI_CMD:   cmd_q           <= host_wdata;
                    RI_CFG1:  cfg1_q          <= host_wdata;
                    RI_STAT:  bus_id_out      <= host_wdata;
                    RI_INTR:  sel_timeout_out <= host_wdata;
                    RI_STEP:  sync_period_out <= host_wdata;
                    RI_FLAGS: sync_offset_out <= host_wdata;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_strobe <= 1'b0;
            cmd_code   <= '0;
            cmd_dma    <= 1'b0;
        end else begin
            cmd_strobe <= legal;
            if (legal) begin
                cmd_code <= cmd_in.code;
                cmd_dma  <= cmd_in.dma;
            end
        end
    end

    assign status   = {intr_q != 8'h00, 1'b0, perr_q, tc_q == '0, xdone_q, bus_phase};
    assign fflags   = {seq_step, 5'(fifo_cnt)};
    assign cfg1_out = cfg1_q;

    always_comb begin
        unique case (idx)
            RI_TC_LO:  host_rdata = tc_q[7:0];
            RI_TC_MID: host_rdata = tc_q[15:8];
            RI_TC_HI:  host_rdata = tc_q[23:16];
            RI_FIFO:   host_rdata = fifo_empty ? 8'h00 : fifo_dout;
            RI_CMD:    host_rdata = cmd_q;
            RI_STAT:   host_rdata = status;
            RI_INTR:   host_rdata = intr_q;
            RI_STEP:   host_rdata = {5'b0, seq_step};
            RI_FLAGS:  host_rdata = fflags;
            RI_CFG1:   host_rdata = cfg1_q;
            default:   host_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/scsi_regfront_chk.sv
module scsi_regfront_chk
    import scsi_regfront_pkg::*;
#(
    parameter int FCNT_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              host_wr,
    input logic              host_rd,
    input logic [ADDR_W-1:0] host_addr,
    input logic [7:0]        host_wdata,
    input logic [7:0]        seq_irq,
    input logic              xfer_strobe,
    input logic              cmd_strobe,
    input logic [7:0]        intr_q,
    input logic [TC_W-1:0]   tc_q,
    input logic [FCNT_W-1:0] fifo_cnt,
    input logic [7:0]        cfg1_q,
    input logic [1:0]        link_q
);
    logic [3:0] ix;
    assign ix = host_addr[ADDR_W-1:2];

    AST_STROBE_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        cmd_strobe |-> $past(host_wr && ix == 4'd3)); // R3

    AST_GROUP4_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (host_wr && ix == 4'd3 && host_wdata[6:0] >= 7'h40 && host_wdata[6:0] <= 7'h47
         && link_q != 2'b00) |=> intr_q[6]); // R5

    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (rst)
        fifo_cnt <= FCNT_W'(FIFO_DEPTH)); // R7

    AST_INTR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (host_rd && ix == 4'd5 && seq_irq == 8'h00 && !host_wr) |=> intr_q == 8'h00); // R9

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
        (xfer_strobe && tc_q != '0 && !host_wr) |=> tc_q == $past(tc_q) - 1'b1); // R10

    AST_CHIP_RESET: assert property (@(posedge clk) disable iff (rst)
        (host_wr && ix == 4'd3 && host_wdata[6:0] == 7'h02)
        |=> (tc_q == '0 && fifo_cnt == '0 && cfg1_q == 8'h00 && link_q == 2'b00)); // R11
endmodule

bind scsi_regfront scsi_regfront_chk #(.FCNT_W(FCNT_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .seq_irq    (seq_irq),
    .xfer_strobe(xfer_strobe),
    .cmd_strobe (cmd_strobe),
    .intr_q     (intr_q),
    .tc_q       (tc_q),
    .fifo_cnt   (fifo_cnt),
    .cfg1_q     (cfg1_q),
    .link_q     (link_q)
);

// File: tb/scsi_regfront_tb.sv
module scsi_regfront_tb_top;
    logic       clk = 0;
    logic       rst = 1;
    logic       host_wr = 0, host_rd = 0;
    logic [5:0] host_addr = 0;
    logic [7:0] host_wdata = 0, host_rdata;
    logic       seq_state_ld = 0;
    logic [1:0] seq_state_in = 0;
    logic [2:0] seq_step = 0;
    logic [7:0] seq_irq = 0;
    logic       seq_xfer_done = 0, par_err = 0, xfer_strobe = 0;
    logic [2:0] bus_phase = 0;
    logic       cmd_strobe, cmd_dma;
    logic [6:0] cmd_code;
    logic [7:0] cfg1_out, bus_id_out, sel_timeout_out, sync_period_out, sync_offset_out;

    int n_tests = 0, n_fail = 0;
    bit done = 0;
    logic       got_stb, got_dma;
    logic [6:0] got_code;
    logic [7:0] rv;

    always #5 clk = ~clk;

    scsi_regfront dut_i (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // all tasks enter and leave at a falling edge
    task automatic wr(logic [5:0] a, logic [7:0] d);
        host_wr = 1; host_addr = a; host_wdata = d;
        @(negedge clk);
        got_stb = cmd_strobe; got_code = cmd_code; got_dma = cmd_dma;
        host_wr = 0;
    endtask

    task automatic rd(logic [5:0] a, output logic [7:0] v);
        host_rd = 1; host_addr = a;
        #1 v = host_rdata;
        @(negedge clk);
        host_rd = 0;
    endtask

    task automatic set_link(logic [1:0] s);
        seq_state_ld = 1; seq_state_in = s;
        @(negedge clk);
        seq_state_ld = 0;
    endtask

    task automatic pulse_xfer();
        xfer_strobe = 1; @(negedge clk); xfer_strobe = 0;
    endtask

    function automatic bit exp_legal(int c, int st);
        if (c <= 3) return 1;
        if (c >= 'h10 && c <= 'h1B) return st == 1 || st == 2;
        if (c >= 'h20 && c <= 'h2B) return st == 2;
        if (c >= 'h40 && c <= 'h47) return st == 0;
        return 0;
    endfunction

    task automatic t_reset();
        rd(6'h10, rv); chk("R8 reset status", rv, 8'h10);
        rd(6'h14, rv); chk("R9 reset intr", rv, 8'h00);
        rd(6'h20, rv); chk("R1 reset cfg1", rv, 8'h00);
        rd(6'h0C, rv); chk("R1 reset cmd byte", rv, 8'h00);
        chk("R3 reset strobe", cmd_strobe, 1'b0);
    endtask

    task automatic t_alias();
        seq_step = 3'd6;
        wr(6'h10, 8'h5A); wr(6'h14, 8'h93); wr(6'h18, 8'h19); wr(6'h1C, 8'h0F);
        chk("R2 bus id out", bus_id_out, 8'h5A);
        chk("R2 timeout out", sel_timeout_out, 8'h93);
        chk("R2 period out", sync_period_out, 8'h19);
        chk("R2 offset out", sync_offset_out, 8'h0F);
        rd(6'h10, rv); chk("R2 status read", rv, 8'h10);
        rd(6'h14, rv); chk("R2 intr read", rv, 8'h00);
        rd(6'h18, rv); chk("R2 step read", rv, 8'h06);
        rd(6'h1C, rv); chk("R2 flags read", rv, 8'hC0);
        wr(6'h20, 8'hC5); rd(6'h20, rv); chk("R1 cfg1 readback", rv, 8'hC5);
        chk("R1 cfg1 out", cfg1_out, 8'hC5);
        wr(6'h20, 8'h00);
        rd(6'h24, rv); chk("R1 unmapped read", rv, 8'h00);
        seq_step = 0;
    endtask

    task automatic t_groups();
        int codes[13] = '{'h00, 'h05, 'h0F, 'h10, 'h1B, 'h1C, 'h1F, 'h20, 'h2B, 'h2C, 'h40, 'h47, 'h48};
        for (int st = 0; st < 4; st++) begin
            set_link(st[1:0]);
            foreach (codes[i]) begin
                for (int d = 0; d < 2; d++) begin
                    logic [7:0] b = {d[0], codes[i][6:0]};
                    bit lg = exp_legal(codes[i], st);
                    wr(6'h0C, b);
                    chk($sformatf("R4 strobe code %0h st %0d", b, st), got_stb, lg);
                    if (lg) begin
                        chk("R3 strobe code", got_code, b[6:0]);
                        chk("R3 strobe dma", got_dma, b[7]);
                    end
                    rd(6'h14, rv);
                    chk($sformatf("R5 illegal bit code %0h st %0d", b, st), rv, lg ? 8'h00 : 8'h40);
                    if (!lg) chk("R5 no strobe", cmd_strobe, 1'b0);
                end
            end
        end
        set_link(2'b00);
    endtask

    task automatic t_busrst();
        wr(6'h0C, 8'h03);
        chk("R6 busrst strobe", got_stb, 1'b1);
        rd(6'h10, rv); chk("R8 pending bit", rv[7], 1'b1);
        rd(6'h14, rv); chk("R6 busrst reported", rv, 8'h80);
        wr(6'h20, 8'h40);
        wr(6'h0C, 8'h03);
        chk("R6 busrst strobe quiet", got_stb, 1'b1);
        rd(6'h14, rv); chk("R6 busrst suppressed", rv, 8'h00);
        wr(6'h20, 8'h00);
    endtask

    task automatic t_fifo();
        seq_step = 3'd5;
        for (int i = 0; i < 17; i++) wr(6'h08, 8'hA0 + 8'(i));
        rd(6'h1C, rv); chk("R7 full flags", rv, 8'hB0);
        for (int i = 0; i < 16; i++) begin
            rd(6'h08, rv); chk("R7 pop order", rv, 8'hA0 + 8'(i));
        end
        rd(6'h08, rv); chk("R7 empty read", rv, 8'h00);
        rd(6'h1C, rv); chk("R7 empty flags", rv, 8'hA0);
        wr(6'h08, 8'h11); wr(6'h08, 8'h22);
        rd(6'h1C, rv); chk("R7 two bytes", rv, 8'hA2);
        wr(6'h0C, 8'h01);
        chk("R7 flush strobe", got_stb, 1'b1);
        rd(6'h1C, rv); chk("R7 flushed", rv, 8'hA0);
        seq_step = 0;
    endtask

    task automatic t_status();
        bus_phase = 3'b011;
        seq_xfer_done = 1; par_err = 1; @(negedge clk); seq_xfer_done = 0; par_err = 0;
        rd(6'h10, rv); chk("R8 sticky status", rv, 8'h3B);
        seq_irq = 8'h08; @(negedge clk); seq_irq = 0;
        rd(6'h10, rv); chk("R8 pending status", rv, 8'hBB);
        host_rd = 1; host_addr = 6'h14; seq_irq = 8'h02;
        #1 rv = host_rdata;
        @(negedge clk); host_rd = 0; seq_irq = 0;
        chk("R9 intr read value", rv, 8'h08);
        rd(6'h14, rv); chk("R9 same-cycle cause kept", rv, 8'h02);
        rd(6'h10, rv); chk("R9 sticky cleared", rv, 8'h13);
        bus_phase = 0;
    endtask

    task automatic t_count();
        wr(6'h00, 8'h03); wr(6'h04, 8'h00); wr(6'h38, 8'h00);
        rd(6'h00, rv); chk("R10 load low", rv, 8'h03);
        rd(6'h10, rv); chk("R10 nonzero status", rv[4], 1'b0);
        pulse_xfer(); pulse_xfer();
        rd(6'h00, rv); chk("R10 two decrements", rv, 8'h01);
        pulse_xfer();
        rd(6'h10, rv); chk("R10 zero status", rv[4], 1'b1);
        pulse_xfer();
        rd(6'h00, rv); chk("R10 hold low", rv, 8'h00);
        rd(6'h38, rv); chk("R10 hold high", rv, 8'h00);
        wr(6'h38, 8'h12); rd(6'h38, rv); chk("R10 load high", rv, 8'h12);
        wr(6'h04, 8'h00); pulse_xfer();
        rd(6'h04, rv); chk("R10 borrow mid", rv, 8'hFF);
        rd(6'h38, rv); chk("R10 borrow high", rv, 8'h11);
    endtask

    task automatic t_chiprst();
        wr(6'h20, 8'h07); wr(6'h10, 8'h33); wr(6'h08, 8'h44);
        wr(6'h00, 8'h05);
        set_link(2'b01);
        wr(6'h0C, 8'h40);
        wr(6'h0C, 8'h02);
        chk("R11 chip reset strobe", got_stb, 1'b1);
        chk("R11 chip reset code", got_code, 7'h02);
        rd(6'h20, rv); chk("R11 cfg1 cleared", rv, 8'h00);
        rd(6'h1C, rv); chk("R11 fifo cleared", rv, 8'h00);
        rd(6'h00, rv); chk("R11 count cleared", rv, 8'h00);
        rd(6'h14, rv); chk("R11 intr cleared", rv, 8'h00);
        rd(6'h0C, rv); chk("R11 cmd byte cleared", rv, 8'h00);
        chk("R11 bus id cleared", bus_id_out, 8'h00);
        wr(6'h0C, 8'h41);
        chk("R11 disconnected state", got_stb, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_alias();
        t_groups();
        t_busrst();
        t_fifo();
        t_status();
        t_count();
        t_chiprst();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule